// File: doc/BRIEF.md
# Wrapping Up-Count Timer

This block is a 32-bit general-purpose event timer that counts upward and signals an event when the count wraps past the all-ones value. Software picks a start value. To get an event after a given number of counts, it loads all-ones minus that number. Counting then begins from the start value. When the counter wraps, an overflow flag is raised. In one-shot mode the counter then halts. In periodic mode it restarts from the start value, so the reload value `0xFFFFFFFF - (P - 1)` gives one event every P cycles.

A small register port gives access to the control, start value, live count, interrupt enable and interrupt status. Writes to the three counting registers are posted. They travel through a fixed three-stage resynchronisation pipeline, in order, before they change the counting logic. A pending bit shows that such a write is still in flight. Writes to the interrupt registers take effect at once. Stopping the counter freezes its value, which stays readable and can be written back before counting is restarted.

Top module: `wrap_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and the pending bit is low.
- R2: A write to CONTROL (address 0), START (address 1) or COUNT (address 2) changes that register exactly 3 clock edges after the edge that captured it. Until then a read returns the old value. Posted writes are applied in the order they were issued.
- R3: PENDING (address 5, bit 0) reads 1 from the edge that captures a posted write until the edge that applies the last posted write in flight.
- R4: While CONTROL bit 0 (run) is 1, the count rises by one each cycle. When run is cleared, the count holds its value and reads back at address 2.
- R5: Applying a CONTROL write with bit 2 (load-now) set copies the START value into the count. Bit 2 always reads back 0, and CONTROL reads {auto-reload, run} in bits 1:0.
- R6: A running count at 0xFFFFFFFF overflows on the next edge and sets STATUS (address 4) bit 0.
- R7: With CONTROL bit 1 (auto-reload) set, an overflow reloads the count from START. The count keeps running, so with START = L the period is 0xFFFFFFFF - L + 1 cycles.
- R8: With auto-reload clear, an overflow leaves the count at 0 and clears the run bit.
- R9: Writing 1 to STATUS bit 0 clears it at once. Writing 0 has no effect. An overflow in the same cycle as a clear wins, and the flag stays set.
- R10: `irq` is a level equal to STATUS bit 0 AND ENABLE (address 3, bit 0). ENABLE writes take effect at once.
- R11: Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest case to reach is a status clear that lands on the very edge where the counter overflows. Reaching it means lining up a posted COUNT write, a posted CONTROL write and an immediate STATUS write so that each arrives on its own cycle. The stimulus stops the counter and writes COUNT to 0xFFFFFFFE and then CONTROL to run, on back-to-back cycles. It then counts edges through the three-stage pipeline and places the clearing write on the overflow edge. The posted-latency checks read each register one cycle before and again on the cycle its write lands.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int unsigned WT_DW = 32;
  localparam int unsigned WT_AW = 3;

  // register addresses
  localparam logic [WT_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [WT_AW-1:0] A_START = 3'd1;
  localparam logic [WT_AW-1:0] A_COUNT = 3'd2;
  localparam logic [WT_AW-1:0] A_IEN   = 3'd3;
  localparam logic [WT_AW-1:0] A_STAT  = 3'd4;
  localparam logic [WT_AW-1:0] A_PEND  = 3'd5;

  // control bit positions
  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_ARL   = 1;
  localparam int unsigned CB_LDNOW = 2;
endpackage

// File: rtl/wt_post_pipe.sv
module wt_post_pipe #(
  parameter int unsigned AW  = 3,
  parameter int unsigned DW  = 32,
  parameter int unsigned LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic          busy
);
  localparam int unsigned LAST = LAT - 1;

  logic [LAT-1:0] vld_q;
  logic [AW-1:0]  addr_q [LAT];
  logic [DW-1:0]  data_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < LAT; s++) begin
        addr_q[s] <= '0;
        data_q[s] <= '0;
      end
    end else begin
      vld_q[0] <= in_vld;
      if (in_vld) begin
        addr_q[0] <= in_addr;
        data_q[0] <= in_data;
      end
      for (int s = 1; s < LAT; s++) begin
        vld_q[s] <= vld_q[s-1];
        if (vld_q[s-1]) begin
          addr_q[s] <= addr_q[s-1];
          data_q[s] <= data_q[s-1];
        end
      end
    end
  end

  assign out_vld  = vld_q[LAST];
  assign out_addr = addr_q[LAST];
  assign out_data = data_q[LAST];
  assign busy     = |vld_q;
endmodule

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ap_vld,
  input  logic [AW-1:0] ap_addr,
  input  logic [DW-1:0] ap_data,
  output logic          run_q,
  output logic          arl_q,
  output logic [DW-1:0] start_q,
  output logic [DW-1:0] cnt_q,
  output logic          ovf
);
  localparam logic [DW-1:0] ONES = '1;

  logic          run_d, arl_d;
  logic [DW-1:0] start_d, cnt_d;
  logic          upd_en;

  always_comb begin
    run_d   = run_q;
    arl_d   = arl_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    ovf     = 1'b0;
    if (run_q) begin
      if (cnt_q == ONES) begin
        ovf = 1'b1;
        if (arl_q) begin
          cnt_d = start_q;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (ap_vld) begin
      case (ap_addr)
        A_CTRL: begin
          run_d = ap_data[CB_RUN];
          arl_d = ap_data[CB_ARL];
          if (ap_data[CB_LDNOW]) cnt_d = start_q;
        end
        A_START: start_d = ap_data;
        A_COUNT: cnt_d   = ap_data;
        default: ;
      endcase
    end
  end

  assign upd_en = run_q | ap_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      arl_q   <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      run_q   <= run_d;
      arl_q   <= arl_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/wt_irq.sv
module wt_irq
  import wt_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit0,
  output logic          stat_q,
  output logic          en_q,
  output logic          irq
);
  logic stat_d, en_d;
  logic clr, set_en;

  always_comb begin
    clr    = wr_en && (wr_addr == A_STAT) && wr_bit0;
    set_en = wr_en && (wr_addr == A_IEN);
    stat_d = ovf ? 1'b1 : (clr ? 1'b0 : stat_q);
    en_d   = set_en ? wr_bit0 : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (ovf | clr) stat_q <= stat_d;
      if (set_en)    en_q   <= en_d;
    end
  end

  assign irq = stat_q & en_q;
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
  import wt_pkg::*;
#(
  parameter int unsigned DW       = WT_DW,
  parameter int unsigned AW       = WT_AW,
  parameter int unsigned SYNC_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  logic [1:0]    rsync_q;
  logic          rst_core_n;
  logic          post_wr;
  logic          ap_vld;
  logic [AW-1:0] ap_addr;
  logic [DW-1:0] ap_data;
  logic          pend;
  logic          run_q, arl_q, ovf;
  logic [DW-1:0] start_q, cnt_q;
  logic          stat_q, en_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign post_wr = wr_en && ((wr_addr == A_CTRL) || (wr_addr == A_START) ||
                             (wr_addr == A_COUNT));

  wt_post_pipe #(.AW(AW), .DW(DW), .LAT(SYNC_LAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .in_vld   (post_wr),
    .in_addr  (wr_addr),
    .in_data  (wr_data),
    .out_vld  (ap_vld),
    .out_addr (ap_addr),
    .out_data (ap_data),
    .busy     (pend)
  );

  wt_counter #(.AW(AW), .DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ap_vld  (ap_vld),
    .ap_addr (ap_addr),
    .ap_data (ap_data),
    .run_q   (run_q),
    .arl_q   (arl_q),
    .start_q (start_q),
    .cnt_q   (cnt_q),
    .ovf     (ovf)
  );

  wt_irq #(.AW(AW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ovf     (ovf),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit0 (wr_data[0]),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .irq     (irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  begin
        rd_data[CB_RUN] = run_q;
        rd_data[CB_ARL] = arl_q;
      end
      A_START: rd_data    = start_q;
      A_COUNT: rd_data    = cnt_q;
      A_IEN:   rd_data[0] = en_q;
      A_STAT:  rd_data[0] = stat_q;
      A_PEND:  rd_data[0] = pend;
      default: rd_data    = '0;
    endcase
  end
endmodule

// File: rtl/wt_checker.sv
module wt_checker
  import wt_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          ap_vld,
  input logic          pend,
  input logic          run_q,
  input logic          arl_q,
  input logic [DW-1:0] start_q,
  input logic [DW-1:0] cnt_q,
  input logic          stat_q,
  input logic          irq
);
  localparam logic [DW-1:0] ONES = '1;

  logic wrap_now;
  assign wrap_now = run_q && (cnt_q == ONES);

  // R3
  a_r3_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ((wr_addr == A_CTRL) || (wr_addr == A_START) || (wr_addr == A_COUNT)) |=> pend);

  // R4
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !ap_vld && (cnt_q != ONES) |=> cnt_q == DW'($past(cnt_q) + 1'b1));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !ap_vld |=> $stable(cnt_q));

  // R6
  a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_now |=> stat_q);

  // R7
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_now && arl_q && !ap_vld |=> run_q && (cnt_q == $past(start_q)));

  // R8
  a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_now && !arl_q && !ap_vld |=> !run_q && (cnt_q == '0));

  // R9
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr == A_STAT) && wr_data[0] && !wrap_now |=> !stat_q);

  // R10
  a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr == A_IEN) && !wr_data[0] |=> !irq);
endmodule

bind wrap_timer wt_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .ap_vld  (ap_vld),
  .pend    (pend),
  .run_q   (run_q),
  .arl_q   (arl_q),
  .start_q (start_q),
  .cnt_q   (cnt_q),
  .stat_q  (stat_q),
  .irq     (irq)
);

// File: tb/wrap_timer_tb.sv
`timescale 1ns/1ps
module wrap_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wrap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // kind: 0 write, 1 wait cycles, 2 check read, 3 check irq
  localparam int NV = 61;
  localparam logic [68:0] VEC [NV] = '{
    {2'd0, 3'd1, 32'hFFFFFFF0, 32'h0},        // R2 START write
    {2'd2, 3'd5, 32'h0, 32'h1},               // R3 pending
    {2'd1, 3'd0, 32'd2, 32'h0},
    {2'd2, 3'd1, 32'h0, 32'h0},               // R2 not yet applied
    {2'd1, 3'd0, 32'd1, 32'h0},
    {2'd2, 3'd1, 32'h0, 32'hFFFFFFF0},        // R2 applied at 3rd edge
    {2'd2, 3'd5, 32'h0, 32'h0},               // R3 drained
    {2'd0, 3'd0, 32'h7, 32'h0},               // run+arl+load-now
    {2'd1, 3'd0, 32'd3, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFF0},        // R5 load-now
    {2'd2, 3'd0, 32'h0, 32'h3},               // R5 readback
    {2'd1, 3'd0, 32'd5, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFF5},        // R4 counting
    {2'd1, 3'd0, 32'd10, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFFF},        // R6 before wrap
    {2'd2, 3'd4, 32'h0, 32'h0},
    {2'd1, 3'd0, 32'd1, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFF0},        // R7 reload
    {2'd2, 3'd4, 32'h0, 32'h1},               // R6 flag
    {2'd3, 3'd0, 32'h0, 32'h0},               // R10 masked
    {2'd0, 3'd3, 32'h1, 32'h0},               // enable
    {2'd3, 3'd0, 32'h0, 32'h1},               // R10 level
    {2'd2, 3'd3, 32'h0, 32'h1},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFF1},        // R7 keeps running
    {2'd0, 3'd4, 32'h0, 32'h0},               // R9 write 0
    {2'd2, 3'd4, 32'h0, 32'h1},               // R9 no effect
    {2'd0, 3'd4, 32'h1, 32'h0},               // R9 write 1
    {2'd2, 3'd4, 32'h0, 32'h0},
    {2'd3, 3'd0, 32'h0, 32'h0},               // R10 drops
    {2'd0, 3'd0, 32'h0, 32'h0},               // stop
    {2'd1, 3'd0, 32'd3, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFF7},        // R4 stop point
    {2'd2, 3'd0, 32'h0, 32'h0},
    {2'd1, 3'd0, 32'd4, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFF7},        // R4 hold
    {2'd0, 3'd2, 32'hFFFFFFFD, 32'h0},        // restore count
    {2'd0, 3'd0, 32'h1, 32'h0},               // one-shot run
    {2'd1, 3'd0, 32'd2, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFFD},        // R2 order
    {2'd2, 3'd0, 32'h0, 32'h0},
    {2'd1, 3'd0, 32'd1, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFFD},
    {2'd2, 3'd0, 32'h0, 32'h1},
    {2'd1, 3'd0, 32'd2, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'hFFFFFFFF},
    {2'd2, 3'd4, 32'h0, 32'h0},
    {2'd1, 3'd0, 32'd1, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'h0},               // R8 wrap to 0
    {2'd2, 3'd4, 32'h0, 32'h1},               // R6
    {2'd3, 3'd0, 32'h0, 32'h1},               // R10
    {2'd2, 3'd0, 32'h0, 32'h0},               // R8 run cleared
    {2'd1, 3'd0, 32'd3, 32'h0},
    {2'd2, 3'd2, 32'h0, 32'h0},               // R8 stays stopped
    {2'd2, 3'd6, 32'h0, 32'h0},               // R11
    {2'd2, 3'd7, 32'h0, 32'h0},               // R11
    {2'd2, 3'd1, 32'h0, 32'hFFFFFFF0},
    {2'd0, 3'd4, 32'h1, 32'h0},
    {2'd2, 3'd4, 32'h0, 32'h0},
    {2'd3, 3'd0, 32'h0, 32'h0},
    {2'd2, 3'd5, 32'h0, 32'h0},
    {2'd2, 3'd3, 32'h0, 32'h1}
  };

  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    rd_addr = a;
    #0.1;
    n_chk++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, rd_data, e);
    end
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #0.1;
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    for (int a = 0; a < 6; a++) chk_rd(3'(a), 32'h0, "R1");
    chk_irq(1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  kd;
      logic [2:0]  ad;
      logic [31:0] dd, ee;
      {kd, ad, dd, ee} = VEC[i];
      case (kd)
        2'd0: do_wr(ad, dd);
        2'd1: idle(int'(dd));
        2'd2: chk_rd(ad, ee, "R2-R11 vector");
        default: chk_irq(ee[0], "R10 vector");
      endcase
    end

    // R9: overflow on the same edge as a clear keeps the flag set
    do_wr(3'd2, 32'hFFFFFFFE);   // E
    do_wr(3'd0, 32'h1);          // E+1
    idle(4);                     // after E+5
    chk_rd(3'd2, 32'hFFFFFFFF, "R9 setup");
    do_wr(3'd4, 32'h1);          // clear on overflow edge E+6
    chk_rd(3'd4, 32'h1, "R9 set wins");
    chk_rd(3'd2, 32'h0, "R8");
    chk_irq(1'b1, "R10");

    // R1: reset in the middle of periodic counting
    do_wr(3'd0, 32'h7);
    idle(6);
    rst_n = 1'b0;
    #1;
    chk_rd(3'd2, 32'h0, "R1 count");
    chk_rd(3'd0, 32'h0, "R1 ctrl");
    chk_rd(3'd4, 32'h0, "R1 stat");
    chk_rd(3'd1, 32'h0, "R1 start");
    chk_irq(1'b0, "R1");
    idle(2);
    rst_n = 1'b1;
    idle(3);
    chk_rd(3'd2, 32'h0, "R1 after release");
    finish_run();
  end
endmodule